// File: doc/BRIEF.md
# Dual-Use Analog/Digital Pin Controller

This block governs a small group of pins, each of which either feeds the analog input multiplexer or works as a general-purpose digital line. Three byte-wide registers on a simple register bus set the behaviour. A mode register chooses analog or digital for each pin. A direction register chooses whether a digital pin drives or receives. A level register holds the values that output pins drive. The block drives an output enable and an output level for each pad, and it samples each pad's input level through a two-stage synchronizer. Every pad level is also passed unchanged to the analog multiplexer tap, whatever its mode, so a pin in digital use can still be converted as a test.

The mode register takes priority. A pin in analog mode never has its driver enabled, and its direction and level bits do nothing. For a digital pin, the direction bit picks between driving the stored level and receiving. A read of the level register returns the synchronized pad level for digital input pins. For all other pins it returns the stored bit. Inside the RTL, each pin's decoded mode is an enumerated value with three states: analog, digital-in and digital-out. Analog applies when the mode bit is 0. Digital-in applies when the mode bit is 1 and the direction bit is 1. Digital-out applies when the mode bit is 1 and the direction bit is 0. The pin follows any register write in the cycle after the write edge, with no intermediate state.

Top module: `dio_pin_ctl`

## Requirements
- R1: After reset the mode register (address 6h) reads 00h, the direction register (address 5h) reads FFh and the level register (address 4h) reads 00h. No pin output enable is asserted.
- R2: A pin whose mode bit is 0 (analog) never has its output enable asserted, whatever its direction and level bits hold.
- R3: A pin whose mode bit is 1 and whose direction bit is 0 has its output enable asserted and drives its level register bit (0 = low, 1 = high). The output level of every other pin is 0.
- R4: A pin whose mode bit is 1 and whose direction bit is 1 is an input, and its output enable is deasserted.
- R5: A level register read returns, for each digital input pin, the pad level after two synchronizer flops. A level that changes just before a read edge is not seen by that read. A level that has been stable for two edges before the read edge is seen.
- R6: A level register read returns the stored bit for analog pins and for digital output pins, whatever the pad level.
- R7: Writes land in the level register at address 4h, the direction register at 5h and the mode register at 6h. A write to any other address changes nothing, and a read of any other address returns 00h.
- R8: Read data is registered. It appears after the clock edge that samples the read strobe and holds its value until the next read, writes included.
- R9: The analog tap output equals the pad input level of every pin in every mode.
- R10: When PIN_COUNT is below 8, the register bits above PIN_COUNT read as 0, and writes to them have no effect on the pins or on read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| rd_en | input | 1 | Register read strobe, sampled on the rising edge |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | PIN_COUNT | Pad input levels |
| pin_oe | output | PIN_COUNT | Pad output enables |
| pin_out | output | PIN_COUNT | Pad output levels |
| ana_tap | output | PIN_COUNT | Pad levels forwarded to the analog multiplexer |

## Verification
Output enables and output levels follow a write in the cycle right after the write edge. The bench samples them at the next falling edge. Read data is valid after the edge that samples the read strobe, so each read is checked one falling edge later. A pad change takes two edges to reach the read path. Random stimulus therefore holds each new pad pattern for three cycles before any read. One directed case reads in the very first edge after a change and expects the old level.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int REG_W    = 8;
    localparam int REG_AW   = 4;

    localparam logic [REG_AW-1:0] ADDR_LEVEL = 4'h4;
    localparam logic [REG_AW-1:0] ADDR_DIR   = 4'h5;
    localparam logic [REG_AW-1:0] ADDR_MODE  = 4'h6;

    typedef enum logic [1:0] {
        PM_ANALOG  = 2'd0,
        PM_DIG_IN  = 2'd1,
        PM_DIG_OUT = 2'd2
    } pin_mode_e;

endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q[g] <= 1'b0;
                stage2_q[g] <= 1'b0;
            end else begin
                stage1_q[g] <= async_i[g];
                stage2_q[g] <= stage1_q[g];
            end
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/dio_regs.sv
module dio_regs
    import dio_pkg::*;
#(
    parameter int PIN_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    output logic [PIN_COUNT-1:0] level_q,
    output logic [PIN_COUNT-1:0] dir_q,
    output logic [PIN_COUNT-1:0] mode_q
);

    logic hit_level, hit_dir, hit_mode;

    always_comb begin
        hit_level = wr_en && (addr == ADDR_LEVEL);
        hit_dir   = wr_en && (addr == ADDR_DIR);
        hit_mode  = wr_en && (addr == ADDR_MODE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            dir_q   <= '1;
            mode_q  <= '0;
        end else begin
            if (hit_level) level_q <= wdata[PIN_COUNT-1:0];
            if (hit_dir)   dir_q   <= wdata[PIN_COUNT-1:0];
            if (hit_mode)  mode_q  <= wdata[PIN_COUNT-1:0];
        end
    end

    // R7: a mode write is visible after its edge
    p_mode_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_MODE) |=> (mode_q == $past(wdata[PIN_COUNT-1:0])));

    // R7: writes outside the map leave every register untouched
    p_stray_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != ADDR_LEVEL && addr != ADDR_DIR && addr != ADDR_MODE)
        |=> ($stable(level_q) && $stable(dir_q) && $stable(mode_q)));

endmodule

// File: rtl/dio_pad_ctl.sv
module dio_pad_ctl
    import dio_pkg::*;
#(
    parameter int PIN_COUNT = 8
) (
    input  logic [PIN_COUNT-1:0] mode_q,
    input  logic [PIN_COUNT-1:0] dir_q,
    input  logic [PIN_COUNT-1:0] level_q,
    output logic [PIN_COUNT-1:0] pad_oe,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] live_sel
);

    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
        pin_mode_e pmode;

        always_comb begin
            if (!mode_q[g])     pmode = PM_ANALOG;
            else if (dir_q[g])  pmode = PM_DIG_IN;
            else                pmode = PM_DIG_OUT;
        end

        always_comb begin
            pad_oe[g]   = 1'b0;
            pad_out[g]  = 1'b0;
            live_sel[g] = 1'b0;
            unique case (pmode)
                PM_ANALOG: begin
                end
                PM_DIG_IN: begin
                    live_sel[g] = 1'b1;
                end
                PM_DIG_OUT: begin
                    pad_oe[g]  = 1'b1;
                    pad_out[g] = level_q[g];
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/dio_read_port.sv
module dio_read_port
    import dio_pkg::*;
#(
    parameter int PIN_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [REG_AW-1:0]    addr,
    input  logic [PIN_COUNT-1:0] level_q,
    input  logic [PIN_COUNT-1:0] dir_q,
    input  logic [PIN_COUNT-1:0] mode_q,
    input  logic [PIN_COUNT-1:0] live_sel,
    input  logic [PIN_COUNT-1:0] pin_sync,
    output logic [REG_W-1:0]     rdata
);

    logic [PIN_COUNT-1:0] sel_bits;
    logic [REG_W-1:0]     rd_next;

    always_comb begin
        unique case (addr)
            ADDR_LEVEL: sel_bits = (live_sel & pin_sync) | (~live_sel & level_q);
            ADDR_DIR:   sel_bits = dir_q;
            ADDR_MODE:  sel_bits = mode_q;
            default:    sel_bits = '0;
        endcase
        rd_next = '0;
        rd_next[PIN_COUNT-1:0] = sel_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

    // R8: read data holds between reads
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    if (PIN_COUNT < REG_W) begin : g_narrow
        // R10: bits above the pin count never read as 1
        p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            rdata[REG_W-1:PIN_COUNT] == '0);
    end

endmodule

// File: rtl/dio_pin_ctl.sv
module dio_pin_ctl
    import dio_pkg::*;
#(
    parameter int PIN_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [3:0]           addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] ana_tap
);

    logic [PIN_COUNT-1:0] level_q, dir_q, mode_q;
    logic [PIN_COUNT-1:0] live_sel, pin_sync;

    dio_regs #(.PIN_COUNT(PIN_COUNT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .level_q (level_q),
        .dir_q   (dir_q),
        .mode_q  (mode_q)
    );

    dio_pad_ctl #(.PIN_COUNT(PIN_COUNT)) u_pad (
        .mode_q   (mode_q),
        .dir_q    (dir_q),
        .level_q  (level_q),
        .pad_oe   (pin_oe),
        .pad_out  (pin_out),
        .live_sel (live_sel)
    );

    dio_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    dio_read_port #(.PIN_COUNT(PIN_COUNT)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .addr     (addr),
        .level_q  (level_q),
        .dir_q    (dir_q),
        .mode_q   (mode_q),
        .live_sel (live_sel),
        .pin_sync (pin_sync),
        .rdata    (rdata)
    );

    assign ana_tap = pin_in;

    // R2: analog pins never drive
    p_analog_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~mode_q) == '0);

    // R3: a level is driven only where the driver is enabled
    p_out_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    // R4: input-direction pins never drive
    p_input_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & dir_q) == '0);

endmodule

// File: tb/dio_pin_ctl_tb_top.sv
module dio_pin_ctl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, pin_in = '0, pin_oe, pin_out, ana_tap;

    logic       n_wr = 1'b0, n_rd = 1'b0;
    logic [3:0] n_addr = '0;
    logic [7:0] n_wdata = '0, n_rdata;
    logic [3:0] n_pin_in = '0, n_oe, n_out, n_tap;

    int tests = 0;
    int fails = 0;

    logic [7:0] m_mode, m_dir, m_level, m_pin;

    always #(CLK_PERIOD/2) clk = ~clk;

    dio_pin_ctl #(.PIN_COUNT(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .ana_tap(ana_tap)
    );

    dio_pin_ctl #(.PIN_COUNT(4)) dut4_i (
        .clk(clk), .rst_n(rst_n), .wr_en(n_wr), .rd_en(n_rd), .addr(n_addr),
        .wdata(n_wdata), .rdata(n_rdata), .pin_in(n_pin_in), .pin_oe(n_oe),
        .pin_out(n_out), .ana_tap(n_tap)
    );

    function automatic logic [7:0] f_oe();
        return m_mode & ~m_dir;
    endfunction

    function automatic logic [7:0] f_out();
        return m_mode & ~m_dir & m_level;
    endfunction

    function automatic logic [7:0] f_read(input logic [3:0] a);
        logic [7:0] live;
        live = m_mode & m_dir;
        case (a)
            4'h4:    return (live & m_pin) | (~live & m_level);
            4'h5:    return m_dir;
            4'h6:    return m_mode;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            4'h4: m_level = d;
            4'h5: m_dir   = d;
            4'h6: m_mode  = d;
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p; m_pin = p;
        repeat (3) @(negedge clk);
    endtask

    task automatic n_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        n_wr = 1'b1; n_addr = a; n_wdata = d;
        @(negedge clk);
        n_wr = 1'b0;
    endtask

    task automatic n_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        n_rd = 1'b1; n_addr = a;
        @(negedge clk);
        n_rd = 1'b0;
        d = n_rdata;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rv, old_exp, held;
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        m_mode = 8'h00; m_dir = 8'hFF; m_level = 8'h00; m_pin = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        bus_read(4'h6, rv); check("R1 mode reset", rv, 8'h00);
        bus_read(4'h5, rv); check("R1 dir reset", rv, 8'hFF);
        bus_read(4'h4, rv); check("R1 level reset", rv, 8'h00);
        check("R1 oe reset", pin_oe, 8'h00);

        // R2 analog pins ignore direction and level
        bus_write(4'h5, 8'h00);
        bus_write(4'h4, 8'hFF);
        check("R2 analog oe", pin_oe, 8'h00);
        check("R2 analog out", pin_out, 8'h00);

        // R3 outputs drive stored level
        bus_write(4'h4, 8'hA5);
        bus_write(4'h6, 8'hFF);
        check("R3 oe", pin_oe, 8'hFF);
        check("R3 out", pin_out, 8'hA5);

        // R4 upper nibble becomes input
        bus_write(4'h5, 8'hF0);
        check("R4 oe", pin_oe, 8'h0F);
        check("R4 out", pin_out, 8'h05);

        // R5 synchronizer latency
        set_pins(8'h00);
        old_exp = f_read(4'h4);
        @(negedge clk);
        pin_in = 8'hC3; rd_en = 1'b1; addr = 4'h4;
        @(negedge clk);
        rd_en = 1'b0;
        check("R5 early read sees old level", rdata, old_exp);
        m_pin = 8'hC3;
        repeat (3) @(negedge clk);
        bus_read(4'h4, rv); check("R5 settled read", rv, 8'hC5);

        // R6 stored bits for analog and output pins
        bus_write(4'h6, 8'h0F);
        set_pins(8'h5A);
        bus_read(4'h4, rv); check("R6 stored bits", rv, f_read(4'h4));
        check("R6 stored bits literal", rv, 8'hA5);

        // R7 stray addresses
        bus_write(4'h3, 8'h77);
        bus_write(4'h7, 8'h77);
        bus_read(4'h6, rv); check("R7 mode unchanged", rv, 8'h0F);
        bus_read(4'h3, rv); check("R7 stray read 3", rv, 8'h00);
        bus_read(4'h7, rv); check("R7 stray read 7", rv, 8'h00);
        bus_read(4'h0, rv); check("R7 stray read 0", rv, 8'h00);

        // R8 read data holds across writes
        bus_read(4'h5, held);
        bus_write(4'h5, 8'h3C);
        @(negedge clk);
        check("R8 hold", rdata, held);

        // R9 analog tap in every mode
        check("R9 tap mixed", ana_tap, pin_in);
        bus_write(4'h6, 8'hFF);
        set_pins(8'h96);
        check("R9 tap digital", ana_tap, 8'h96);

        // R10 four-pin variant
        n_read(4'h5, rv); check("R10 narrow dir reset", rv, 8'h0F);
        n_write(4'h6, 8'hFF);
        n_read(4'h6, rv); check("R10 narrow mode", rv, 8'h0F);
        n_write(4'h5, 8'hF0);
        n_write(4'h4, 8'hFF);
        check("R10 narrow oe", {4'h0, n_oe}, 8'h0F);
        n_read(4'h4, rv); check("R10 narrow level", rv, 8'h0F);

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [3:0] a;
            logic [7:0] d;
            set_pins(8'($urandom));
            a = 4'($urandom_range(3, 7));
            d = 8'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                bus_write(a, d);
                check("R3 random out", pin_out, f_out());
                check("R2 random oe", pin_oe, f_oe());
            end else begin
                bus_read(a, rv);
                check("R5 random read", rv, f_read(a));
            end
            check("R9 random tap", ana_tap, m_pin);
        end

        finish_run();
    end

endmodule